// File: doc/BRIEF.md
# Auxiliary Packet Link Controller

This block moves short auxiliary packets across a serial link that also carries real-time frames. Software uses a word-addressed memory bus. It fills a transmit buffer, writes the packet length in bytes, and sets a start flag. The controller then streams the packet to the link-layer transmitter as a start marker, the payload words and an end marker. It pauses whenever the link layer reports that a real-time frame is on the wire. In the other direction it takes marked words from the link-layer receiver and stores the payload in a receive buffer. It then raises a present flag with the length in bytes. Software reads the packet and releases the buffer by writing 1 to that flag.

Both link-side streams use valid/ready. On the transmit side, a word is transferred on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_kind` and `tx_data` stay constant. `tx_valid` may drop without a transfer only because `rt_busy` rose or `link_ready` fell; the same word is offered again afterwards. On the receive side, `rx_ready` equals `link_ready`, so the receiver never applies back-pressure to a ready link. Control and status pins are plain levels.

Top module: `aux_link_ctrl`

## Requirements
- R1: After reset `tx_valid` is 0, and the registers at word addresses 513 (transmit busy), 514 (receive length), 515 (receive present) and 516 (overflow) read 0.
- R2: A bus write takes effect on the clock edge where `bus_wr` is sampled high. A read sampled on an edge presents its value on `bus_rdata` after that edge, and `bus_rdata` holds until the next read. Address 512 reads back the transmit length. An unmapped address reads 0.
- R3: The transmit length at address 512 is in bytes, and the word count is the length divided by 4, with bits 1:0 ignored. A start request whose word count is not between 1 and 15 is ignored.
- R4: Writing a value with bit 0 set to address 513 starts a transmission. Address 513 then reads 1 until the end marker has been transferred, and reads 0 from the next cycle on. A start write made while a transmission is in progress is ignored.
- R5: A packet is sent as kind 1 (start, data 0), then kind 2 for each payload word in buffer order from address 0, then kind 3 (end, data 0). Kind 0 means no word.
- R6: `tx_valid` is 0 in every cycle where `rt_busy` is 1. Across such pauses and back-pressure, every word is sent exactly once and in order, and a stalled word keeps its kind and data.
- R7: While `link_ready` is 0, start writes are ignored and both `tx_valid` and `rx_ready` are 0.
- R8: A received start marker, followed by 1 to 15 data words and an end marker, sets the present flag (515 reads 1). Address 514 then reads 4 times the word count, and word i of the payload reads at address 256+i.
- R9: Writing a value with bit 0 set to 515 clears the present flag. A write with bit 0 clear has no effect.
- R10: A start marker that arrives while the present flag is set causes that whole packet to be dropped, leaving the buffer and the length unchanged. It also sets a sticky overflow flag at 516, which a write with bit 0 set clears.
- R11: A received packet with zero data words, one with more than 15 data words, and data words outside a start/end pair do not set the present flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_ready | input | 1 | Link initialised and usable |
| rt_busy | input | 1 | Real-time frame being sent on the link |
| bus_addr | input | 10 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| tx_valid | output | 1 | Transmit word offered |
| tx_ready | input | 1 | Link layer accepts the transmit word |
| tx_kind | output | 2 | Transmit word kind: 0 none, 1 start, 2 data, 3 end |
| tx_data | output | 32 | Transmit word |
| rx_valid | input | 1 | Receive word offered |
| rx_ready | output | 1 | Controller accepts receive words |
| rx_kind | input | 2 | Receive word kind, same coding as transmit |
| rx_data | input | 32 | Receive word |

## Verification
The hardest situation to reach is a transmit word that is stalled both by `tx_ready` low and by `rt_busy` high at once, including the edge where the end marker is accepted. The bench drives both pins at random on every cycle while packets of random length run over a loopback into the receiver. A queue model predicts every offered word, so a lost, repeated or altered word shows up at once. Overflow needs a second packet to arrive while the first is still unread; the loopback delivers it by starting a second transmission before the present flag is cleared.

// File: rtl/aux_link_pkg.sv
package aux_link_pkg;
  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_SOP  = 2'd1;
  localparam logic [1:0] KIND_DATA = 2'd2;
  localparam logic [1:0] KIND_EOP  = 2'd3;

  localparam int ADDR_RX_BASE = 256;
  localparam int ADDR_TX_LEN  = 512;
  localparam int ADDR_TX_GO   = 513;
  localparam int ADDR_RX_LEN  = 514;
  localparam int ADDR_RX_FLAG = 515;
  localparam int ADDR_RX_OVF  = 516;

  typedef enum logic [1:0] {S_IDLE, S_SOP, S_DATA, S_EOP} tx_state_e;
endpackage

// File: rtl/aux_word_ram.sv
module aux_word_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/aux_tx_engine.sv
module aux_tx_engine
  import aux_link_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_ready,
  input  logic            rt_busy,
  input  logic            start,
  input  logic [IDXW-1:0] start_words,
  output logic [IDXW-1:0] rd_idx,
  input  logic [DW-1:0]   rd_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [1:0]      tx_kind,
  output logic [DW-1:0]   tx_data,
  output logic            busy
);
  tx_state_e       state;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] last;
  logic            fire;

  assign fire = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      last  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_SOP;
          idx   <= '0;
          last  <= start_words - 1'b1;
        end
        S_SOP:  if (fire) state <= S_DATA;
        S_DATA: if (fire) begin
          if (idx == last) state <= S_EOP;
          else             idx   <= idx + 1'b1;
        end
        S_EOP:  if (fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign tx_valid = busy && link_ready && !rt_busy;
  assign rd_idx   = idx;

  always_comb begin
    tx_kind = KIND_NONE;
    tx_data = '0;
    case (state)
      S_SOP:  tx_kind = KIND_SOP;
      S_DATA: begin
        tx_kind = KIND_DATA;
        tx_data = rd_data;
      end
      S_EOP:  tx_kind = KIND_EOP;
      default: tx_kind = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/aux_rx_engine.sv
module aux_rx_engine
  import aux_link_pkg::*;
#(
  parameter int DW        = 32,
  parameter int IDXW      = 4,
  parameter int MAX_WORDS = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_ready,
  input  logic            rx_valid,
  input  logic [1:0]      rx_kind,
  input  logic [DW-1:0]   rx_data,
  output logic            rx_ready,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  input  logic            clr_present,
  input  logic            clr_overflow,
  output logic            present,
  output logic [IDXW+1:0] len_bytes,
  output logic            overflow
);
  localparam logic [IDXW-1:0] CAP = IDXW'(MAX_WORDS);

  logic            take;
  logic            collecting;
  logic            too_long;
  logic [IDXW-1:0] cnt;

  assign rx_ready = link_ready;
  assign take     = rx_valid && rx_ready;
  assign wr_en    = take && (rx_kind == KIND_DATA) && collecting && (cnt != CAP);
  assign wr_idx   = cnt;
  assign wr_data  = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      too_long   <= 1'b0;
      cnt        <= '0;
      present    <= 1'b0;
      overflow   <= 1'b0;
      len_bytes  <= '0;
    end else begin
      if (clr_present)  present  <= 1'b0;
      if (clr_overflow) overflow <= 1'b0;
      if (take) begin
        case (rx_kind)
          KIND_SOP: begin
            too_long <= 1'b0;
            cnt      <= '0;
            if (present) begin
              collecting <= 1'b0;
              overflow   <= 1'b1;
            end else begin
              collecting <= 1'b1;
            end
          end
          KIND_DATA: if (collecting) begin
            if (cnt == CAP) too_long <= 1'b1;
            else            cnt      <= cnt + 1'b1;
          end
          KIND_EOP: begin
            collecting <= 1'b0;
            if (collecting && !too_long && cnt != '0) begin
              present   <= 1'b1;
              len_bytes <= {cnt, 2'b00};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aux_link_ctrl.sv
module aux_link_ctrl
  import aux_link_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 10,
  parameter int MAX_WORDS = 15,
  parameter int LEN_W     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_ready,
  input  logic          rt_busy,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    tx_kind,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [1:0]    rx_kind,
  input  logic [DW-1:0] rx_data
);
  localparam int IDXW  = $clog2(MAX_WORDS + 1);
  localparam int DEPTH = 1 << IDXW;
  localparam int PAGEW = AW - IDXW;
  localparam logic [PAGEW-1:0] RX_PAGE = PAGEW'(ADDR_RX_BASE >> IDXW);

  logic [LEN_W-1:0] tx_len_q;
  logic [LEN_W-3:0] len_words;
  logic             len_ok;
  logic             tx_busy;
  logic             start_req;
  logic [IDXW-1:0]  tx_rd_idx;
  logic [DW-1:0]    tx_rd_data;
  logic             rx_wr_en;
  logic [IDXW-1:0]  rx_wr_idx;
  logic [DW-1:0]    rx_wr_data;
  logic [DW-1:0]    rx_rd_data;
  logic             rx_present;
  logic             rx_overflow;
  logic [IDXW+1:0]  rx_len;
  logic             sel_tx_page;
  logic             sel_rx_page;
  logic             clr_present;
  logic             clr_overflow;
  logic [DW-1:0]    rd_val;

  assign sel_tx_page = (bus_addr[AW-1:IDXW] == '0);
  assign sel_rx_page = (bus_addr[AW-1:IDXW] == RX_PAGE);

  assign len_words = tx_len_q[LEN_W-1:2];
  assign len_ok    = (len_words != '0) && (len_words <= (LEN_W-2)'(MAX_WORDS));
  assign start_req = bus_wr && (bus_addr == AW'(ADDR_TX_GO)) && bus_wdata[0]
                     && !tx_busy && link_ready && len_ok;
  assign clr_present  = bus_wr && (bus_addr == AW'(ADDR_RX_FLAG)) && bus_wdata[0];
  assign clr_overflow = bus_wr && (bus_addr == AW'(ADDR_RX_OVF)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) tx_len_q <= '0;
    else if (bus_wr && bus_addr == AW'(ADDR_TX_LEN)) tx_len_q <= bus_wdata[LEN_W-1:0];
  end

  aux_word_ram #(.DW(DW), .DEPTH(DEPTH)) u_tx_buf (
    .clk     (clk),
    .wr_en   (bus_wr && sel_tx_page),
    .wr_idx  (bus_addr[IDXW-1:0]),
    .wr_data (bus_wdata),
    .rd_idx  (tx_rd_idx),
    .rd_data (tx_rd_data)
  );

  aux_tx_engine #(.DW(DW), .IDXW(IDXW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_ready  (link_ready),
    .rt_busy     (rt_busy),
    .start       (start_req),
    .start_words (IDXW'(len_words)),
    .rd_idx      (tx_rd_idx),
    .rd_data     (tx_rd_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_kind     (tx_kind),
    .tx_data     (tx_data),
    .busy        (tx_busy)
  );

  aux_rx_engine #(.DW(DW), .IDXW(IDXW), .MAX_WORDS(MAX_WORDS)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_ready   (link_ready),
    .rx_valid     (rx_valid),
    .rx_kind      (rx_kind),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .wr_en        (rx_wr_en),
    .wr_idx       (rx_wr_idx),
    .wr_data      (rx_wr_data),
    .clr_present  (clr_present),
    .clr_overflow (clr_overflow),
    .present      (rx_present),
    .len_bytes    (rx_len),
    .overflow     (rx_overflow)
  );

  aux_word_ram #(.DW(DW), .DEPTH(DEPTH)) u_rx_buf (
    .clk     (clk),
    .wr_en   (rx_wr_en),
    .wr_idx  (rx_wr_idx),
    .wr_data (rx_wr_data),
    .rd_idx  (bus_addr[IDXW-1:0]),
    .rd_data (rx_rd_data)
  );

  always_comb begin
    rd_val = '0;
    if (sel_rx_page) rd_val = rx_rd_data;
    else begin
      case (bus_addr)
        AW'(ADDR_TX_LEN):  rd_val = DW'(tx_len_q);
        AW'(ADDR_TX_GO):   rd_val = DW'(tx_busy);
        AW'(ADDR_RX_LEN):  rd_val = DW'(rx_len);
        AW'(ADDR_RX_FLAG): rd_val = DW'(rx_present);
        AW'(ADDR_RX_OVF):  rd_val = DW'(rx_overflow);
        default:           rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/aux_link_ctrl_chk.sv
module aux_link_ctrl_chk
  import aux_link_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_ready,
  input logic          rt_busy,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [1:0]    tx_kind,
  input logic [DW-1:0] tx_data,
  input logic          rx_ready,
  input logic          tx_busy,
  input logic          rx_present,
  input logic [LW-1:0] rx_len
);
  AST_TX_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rt_busy); // R6

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_kind) && $stable(tx_data)))); // R6

  AST_LINK_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |-> (!tx_valid && !rx_ready)); // R7

  AST_VALID_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_busy && tx_kind != KIND_NONE)); // R4

  AST_EOP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_kind == KIND_EOP) |=> !tx_busy); // R4

  AST_PRESENT_HAS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_present |-> (rx_len != '0)); // R8
endmodule

bind aux_link_ctrl aux_link_ctrl_chk #(.DW(DW), .LW($clog2(MAX_WORDS + 1) + 2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_ready (link_ready),
  .rt_busy    (rt_busy),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_kind    (tx_kind),
  .tx_data    (tx_data),
  .rx_ready   (rx_ready),
  .tx_busy    (tx_busy),
  .rx_present (rx_present),
  .rx_len     (rx_len)
);

// File: tb/aux_link_ctrl_bench.sv
module aux_link_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_ready = 1'b0;
  logic        rt_busy = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [1:0]  tx_kind;
  logic [31:0] tx_data;
  logic        rx_valid;
  logic        rx_ready;
  logic [1:0]  rx_kind;
  logic [31:0] rx_data;

  logic        loop_on = 1'b1;
  logic        rand_rt = 1'b0;
  logic        hold_rt = 1'b0;
  logic        inj_valid = 1'b0;
  logic [1:0]  inj_kind = '0;
  logic [31:0] inj_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [33:0] exp_q[$];
  logic [31:0] mbuf [16];
  int          mlen = 0;

  always #5 clk = ~clk;

  assign rx_valid = loop_on ? (tx_valid && tx_ready) : inj_valid;
  assign rx_kind  = loop_on ? tx_kind : inj_kind;
  assign rx_data  = loop_on ? tx_data : inj_data;

  aux_link_ctrl u_aux_link_ctrl (
    .clk(clk), .rst_n(rst_n), .link_ready(link_ready), .rt_busy(rt_busy),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_kind(tx_kind), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_kind(rx_kind), .rx_data(rx_data)
  );

  // Reference model of the transmit stream (R3, R4, R5, R7)
  always @(posedge clk) begin
    if (rst_n) begin
      if (bus_wr && bus_addr == 10'd513 && bus_wdata[0] && exp_q.size() == 0
          && link_ready && (mlen / 4) >= 1 && (mlen / 4) <= 15) begin
        exp_q.push_back({2'd1, 32'd0});
        for (int i = 0; i < mlen / 4; i++) exp_q.push_back({2'd2, mbuf[i]});
        exp_q.push_back({2'd3, 32'd0});
      end
      if (tx_valid && tx_ready && exp_q.size() > 0) void'(exp_q.pop_front());
      if (bus_wr && bus_addr < 10'd16) mbuf[bus_addr[3:0]] = bus_wdata;
      if (bus_wr && bus_addr == 10'd512) mlen = int'(bus_wdata[15:0]);
    end
  end

  // Per-cycle comparison of the transmit stream (R1, R5, R6, R7)
  always @(negedge clk) begin
    rt_busy  <= hold_rt || (rand_rt && ($urandom % 4 == 0));
    tx_ready <= ($urandom % 3 != 0);
    #1;
    if (!done) begin
      logic        ev;
      logic [33:0] hd;
      ev = rst_n && exp_q.size() > 0 && link_ready && !rt_busy;
      hd = (exp_q.size() > 0) ? exp_q[0] : 34'd0;
      checks++;
      if (tx_valid !== ev) begin
        fails++;
        $display("FAIL R6 tx_valid actual=%0b expected=%0b t=%0t", tx_valid, ev, $time);
      end else if (ev && {tx_kind, tx_data} !== hd) begin
        fails++;
        $display("FAIL R5 tx word actual=%0h expected=%0h t=%0t", {tx_kind, tx_data}, hd, $time);
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = 10'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    #2;
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic inject(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk);
    inj_kind = k; inj_data = d; inj_valid = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic wait_tx_done();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic send_packet(input int n, input int extra);
    for (int i = 0; i < n; i++) bus_write(i, $urandom);
    bus_write(512, 32'(n * 4 + extra));
    bus_write(513, 32'd1);
    wait_tx_done();
  endtask

  task automatic check_rx(input int n, input string tag);
    bus_check(515, 32'd1, tag);
    bus_check(514, 32'(n * 4), tag);
    for (int i = 0; i < n; i++) bus_check(256 + i, mbuf[i], tag);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] keep [16];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    bus_check(513, 0, "R1 busy");
    bus_check(514, 0, "R1 rx_len");
    bus_check(515, 0, "R1 present");
    bus_check(516, 0, "R1 overflow");

    // R7: start ignored before link_ready
    bus_write(0, 32'h1234_5678);
    bus_write(512, 32'd4);
    bus_write(513, 32'd1);
    bus_check(513, 0, "R7 start while link down");
    checks++;
    if (rx_ready !== 1'b0) begin fails++; $display("FAIL R7 rx_ready actual=%0b expected=0", rx_ready); end
    link_ready = 1'b1;

    // R2: register readback and unmapped address
    bus_write(512, 32'h0000_0abc);
    bus_check(512, 32'h0000_0abc, "R2 tx_len readback");
    bus_check(700, 0, "R2 unmapped");

    // R3: out-of-range lengths are ignored
    bus_write(512, 32'd0);
    bus_write(513, 32'd1);
    bus_check(513, 0, "R3 zero length");
    bus_write(512, 32'd64);
    bus_write(513, 32'd1);
    bus_check(513, 0, "R3 sixteen words");

    // R5 R8: one-word packet with low length bits set, under real-time traffic
    rand_rt = 1'b1;
    send_packet(1, 3);
    check_rx(1, "R8 single word");
    bus_check(513, 0, "R4 self clear");

    // R10: second packet while present is dropped
    for (int i = 0; i < 16; i++) keep[i] = mbuf[i];
    send_packet(2, 0);
    bus_check(516, 1, "R10 overflow set");
    bus_check(514, 4, "R10 length kept");
    bus_check(256, keep[0], "R10 data kept");
    // R9: write 0 has no effect, write 1 clears
    bus_write(515, 32'd0);
    bus_check(515, 1, "R9 write zero");
    bus_write(515, 32'd1);
    bus_check(515, 0, "R9 clear");
    bus_check(516, 1, "R10 sticky");
    bus_write(516, 32'd1);
    bus_check(516, 0, "R10 clear");

    // R4: busy while paused, second start ignored
    hold_rt = 1'b1;
    for (int i = 0; i < 3; i++) bus_write(i, $urandom);
    bus_write(512, 32'd12);
    bus_write(513, 32'd1);
    bus_write(513, 32'd1);
    bus_check(513, 1, "R4 busy while paused");
    hold_rt = 1'b0;
    wait_tx_done();
    check_rx(3, "R4 single packet");
    bus_check(516, 0, "R4 no duplicate packet");
    bus_write(515, 32'd1);

    // R6 R8: random lengths including 15 words
    for (int p = 0; p < 6; p++) begin
      int n;
      n = (p == 0) ? 15 : 1 + int'($urandom % 15);
      send_packet(n, 0);
      check_rx(n, "R8 random packet");
      bus_write(515, 32'd1);
    end
    rand_rt = 1'b0;

    // R11: malformed packets injected directly
    loop_on = 1'b0;
    inject(2'd1, 0); inject(2'd3, 0);
    bus_check(515, 0, "R11 empty packet");
    inject(2'd1, 0);
    for (int i = 0; i < 16; i++) inject(2'd2, 32'(i));
    inject(2'd3, 0);
    bus_check(515, 0, "R11 too long");
    inject(2'd2, 32'h55); inject(2'd3, 0);
    bus_check(515, 0, "R11 no start marker");
    inject(2'd1, 0); inject(2'd2, 32'hdead_0001); inject(2'd2, 32'hdead_0002); inject(2'd3, 0);
    bus_check(515, 1, "R8 injected present");
    bus_check(514, 8, "R8 injected length");
    bus_check(257, 32'hdead_0002, "R8 injected word");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule